// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits beside the retire stage of a small in-order core and runs counted loops without any branch instructions in the loop body. When a loop-start instruction retires, the core hands the block an iteration count and a body length. The count comes either from a general register value or from an immediate field, chosen by a select bit. The block turns these into a stack frame holding three things: the first body address, the last body address and the iterations left.

On every later retirement the block compares the retiring address with the last-body address of the top frame. If they match and more than one iteration is left, it decrements the count and, in the same cycle, overrides the next fetch address with the first body address. If they match on the final iteration, it pops the frame and lets execution fall through. Only the final body instruction moves the count, so branches and calls may leave the body and come back freely. There is no early exit, and at most one frame is popped per retired instruction. Badly nested programs, for example inner and outer loops that share an end address, are not detected; they simply leave a stale frame on the stack.

A push onto a full stack, or a start with a zero count or zero body length, is discarded. Each of these sets its own sticky error flag.

Top module: `hwloop_ctrl`

## Requirements
- R1: After synchronous reset the stack is empty, `redirect_valid` is 0 and both error flags are 0.
- R2: When `start_use_imm` is 1 the iteration count is `start_imm_cnt` zero-extended; when it is 0 the count is `start_reg_cnt`.
- R3: A loop started at address P with body length L has its first body address at P+1 and its last body address at P+L. Addresses are instruction indices that wrap modulo 2^16.
- R4: When the retiring address equals the top frame's last body address and more than one iteration is left, `redirect_valid` is 1 in that same cycle with `redirect_pc` equal to the first body address, and the count drops by one.
- R5: When the top frame's last body instruction retires with exactly one iteration left, the frame is popped and `redirect_valid` stays 0.
- R6: A retirement whose address differs from the top frame's last body address has no effect, even if it matches a deeper frame.
- R7: After an inner frame is popped, the enclosing frame becomes the top and resumes looping on its own last body address.
- R8: When several frames share a last body address, one retirement acts only on the top frame; at most one frame is popped per retirement.
- R9: A valid start while DEPTH frames are held is discarded and sets `overflow_err`, which stays 1 until reset.
- R10: A start with a zero count or a zero body length pushes nothing and sets `cfg_err`, which stays 1 until reset; a zero count or length has priority over the overflow check.
- R11: In a cycle where `start_valid` is 1, the retirement inputs are ignored and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | A loop-start instruction retires this cycle |
| start_use_imm | input | 1 | 1 selects the immediate count, 0 the register count |
| start_reg_cnt | input | 16 | Iteration count read from a general register |
| start_imm_cnt | input | IMM_W | Iteration count from the immediate field |
| start_body_len | input | LEN_W | Number of instructions in the loop body |
| start_pc | input | 16 | Address of the loop-start instruction |
| retire_valid | input | 1 | An ordinary instruction retires this cycle |
| retire_pc | input | 16 | Address of the retiring instruction |
| redirect_valid | output | 1 | Override the next fetch address this cycle |
| redirect_pc | output | 16 | Fetch address to use when `redirect_valid` is 1 |
| overflow_err | output | 1 | Sticky: a start was dropped because the stack was full |
| cfg_err | output | 1 | Sticky: a start was dropped for zero count or length |

## Verification
The bench builds the controller with DEPTH=4, IMM_W=6 and LEN_W=8. The shallow stack lets a handful of starts reach the overflow path. The narrow immediate makes the zero-extension and the register/immediate selection visible with small counts. Short body lengths keep loop runs brief enough to cover nested, shared-end and branch-away programs, and also a random mix of starts and retirements within a small address range, where matches against the top and the deeper frames happen often.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    parameter int unsigned LP_PC_W  = 16;
    parameter int unsigned LP_CNT_W = 16;

    typedef logic [LP_PC_W-1:0]  pc_t;
    typedef logic [LP_CNT_W-1:0] cnt_t;

    // One loop level: first body address, last body address, iterations left
    typedef struct packed {
        pc_t  head;
        pc_t  tail;
        cnt_t left;
    } frame_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_PUSH,
        ACT_REPEAT,
        ACT_POP
    } act_e;

    // Last body address: (start + 1) + len - 1
    function automatic pc_t tail_of(input pc_t loop_pc, input pc_t len);
        return loop_pc + len;
    endfunction

endpackage

// File: rtl/hwloop_intake.sv
module hwloop_intake
    import hwloop_pkg::*;
#(
    parameter int unsigned IMM_W = 10,
    parameter int unsigned LEN_W = 12
) (
    input  logic             use_imm,
    input  cnt_t             reg_cnt,
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic [LEN_W-1:0] body_len,
    input  pc_t              loop_pc,
    output frame_t           frame,
    output logic             bad
);

    cnt_t cnt_sel;

    always_comb begin
        cnt_sel    = use_imm ? cnt_t'(imm_cnt) : reg_cnt;
        frame.head = loop_pc + pc_t'(1);
        frame.tail = tail_of(loop_pc, pc_t'(body_len));
        frame.left = cnt_sel;
        bad        = (cnt_sel == '0) || (body_len == '0);
    end

endmodule

// File: rtl/hwloop_decide.sv
module hwloop_decide
    import hwloop_pkg::*;
(
    input  logic   start_valid,
    input  logic   start_bad,
    input  logic   retire_valid,
    input  pc_t    retire_pc,
    input  frame_t top,
    input  logic   empty,
    input  logic   full,
    output act_e   act,
    output logic   redirect_valid,
    output pc_t    redirect_pc,
    output logic   ovf_set,
    output logic   cfg_set
);

    logic hit;

    always_comb begin
        act            = ACT_NONE;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        ovf_set        = 1'b0;
        cfg_set        = 1'b0;
        hit            = retire_valid && !start_valid && !empty && (retire_pc == top.tail);
        if (start_valid) begin
            if (start_bad) begin
                cfg_set = 1'b1;
            end else if (full) begin
                ovf_set = 1'b1;
            end else begin
                act = ACT_PUSH;
            end
        end else if (hit) begin
            if (top.left > cnt_t'(1)) begin
                act            = ACT_REPEAT;
                redirect_valid = 1'b1;
                redirect_pc    = top.head;
            end else begin
                act = ACT_POP;
            end
        end
    end

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  act_e   act,
    input  frame_t push_frame,
    output frame_t top,
    output logic   empty,
    output logic   full
);

    localparam int unsigned SP_W = $clog2(DEPTH + 1);

    frame_t            slot [DEPTH];
    logic   [SP_W-1:0] sp;
    frame_t            pick [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (act == ACT_PUSH && sp == SP_W'(i)) begin
                    slot[i] <= push_frame;
                end else if (act == ACT_REPEAT && sp == SP_W'(i + 1)) begin
                    slot[i].left <= slot[i].left - cnt_t'(1);
                end
            end
            if (act == ACT_PUSH) sp <= sp + SP_W'(1);
            else if (act == ACT_POP) sp <= sp - SP_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_pick
        assign pick[g] = (sp == SP_W'(g + 1)) ? slot[g] : '0;
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) top = top | pick[i];
    end

    assign empty = (sp == '0);
    assign full  = (sp == SP_W'(DEPTH));

    // R9
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_PUSH) |-> !full);

    // R5
    pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_POP) |=> (sp == SP_W'($past(sp) - SP_W'(1))));

    // R4
    repeat_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_REPEAT) |=> $stable(sp));

    // R4
    repeat_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_REPEAT) |=> (top.left == cnt_t'($past(top.left) - cnt_t'(1))));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IMM_W = 10,
    parameter int unsigned LEN_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_valid,
    input  logic                start_use_imm,
    input  logic [LP_CNT_W-1:0] start_reg_cnt,
    input  logic [IMM_W-1:0]    start_imm_cnt,
    input  logic [LEN_W-1:0]    start_body_len,
    input  logic [LP_PC_W-1:0]  start_pc,
    input  logic                retire_valid,
    input  logic [LP_PC_W-1:0]  retire_pc,
    output logic                redirect_valid,
    output logic [LP_PC_W-1:0]  redirect_pc,
    output logic                overflow_err,
    output logic                cfg_err
);

    frame_t new_frame;
    frame_t top;
    logic   start_bad;
    logic   empty;
    logic   full;
    act_e   act;
    logic   ovf_set;
    logic   cfg_set;

    hwloop_intake #(.IMM_W(IMM_W), .LEN_W(LEN_W)) u_intake (
        .use_imm  (start_use_imm),
        .reg_cnt  (start_reg_cnt),
        .imm_cnt  (start_imm_cnt),
        .body_len (start_body_len),
        .loop_pc  (start_pc),
        .frame    (new_frame),
        .bad      (start_bad)
    );

    hwloop_decide u_decide (
        .start_valid    (start_valid),
        .start_bad      (start_bad),
        .retire_valid   (retire_valid),
        .retire_pc      (retire_pc),
        .top            (top),
        .empty          (empty),
        .full           (full),
        .act            (act),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .ovf_set        (ovf_set),
        .cfg_set        (cfg_set)
    );

    hwloop_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .push_frame (new_frame),
        .top        (top),
        .empty      (empty),
        .full       (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow_err <= 1'b0;
            cfg_err      <= 1'b0;
        end else begin
            if (ovf_set) overflow_err <= 1'b1;
            if (cfg_set) cfg_err      <= 1'b1;
        end
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    // R10
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    // R11
    start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> !redirect_valid);

    // R10
    bad_start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_bad) |=> (top == $past(top)));

endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;

    localparam int DEPTH = 4;
    localparam int IMM_W = 6;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_valid = 1'b0;
    logic             start_use_imm = 1'b0;
    logic [15:0]      start_reg_cnt = '0;
    logic [IMM_W-1:0] start_imm_cnt = '0;
    logic [LEN_W-1:0] start_body_len = '0;
    logic [15:0]      start_pc = '0;
    logic             retire_valid = 1'b0;
    logic [15:0]      retire_pc = '0;
    logic             redirect_valid;
    logic [15:0]      redirect_pc;
    logic             overflow_err;
    logic             cfg_err;

    hwloop_ctrl #(.DEPTH(DEPTH), .IMM_W(IMM_W), .LEN_W(LEN_W)) u_hwloop_ctrl (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_use_imm(start_use_imm),
        .start_reg_cnt(start_reg_cnt), .start_imm_cnt(start_imm_cnt),
        .start_body_len(start_body_len), .start_pc(start_pc),
        .retire_valid(retire_valid), .retire_pc(retire_pc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .overflow_err(overflow_err), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // Behavioural reference: queues, top at the back
    logic [15:0] m_head[$];
    logic [15:0] m_tail[$];
    int          m_left[$];
    bit          m_ovf = 0;
    bit          m_cfg = 0;
    bit          exp_rv;
    logic [15:0] exp_rpc;

    // Program table for the runner
    int p_len[int];
    int p_cnt[int];
    bit p_imm[int];

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", cur_tag, what, got, exp);
        end
    endtask

    task automatic step(input bit sv, input bit ui, input logic [15:0] rc,
                        input logic [IMM_W-1:0] ic, input logic [LEN_W-1:0] ln,
                        input logic [15:0] spc, input bit rv, input logic [15:0] rp);
        int cnt;
        bit set_ovf;
        bit set_cfg;
        @(negedge clk);
        start_valid = sv; start_use_imm = ui; start_reg_cnt = rc;
        start_imm_cnt = ic; start_body_len = ln; start_pc = spc;
        retire_valid = rv; retire_pc = rp;
        exp_rv = 0; exp_rpc = '0; set_ovf = 0; set_cfg = 0;
        cnt = ui ? int'(ic) : int'(rc);
        if (sv) begin
            if (cnt == 0 || ln == 0) set_cfg = 1;
            else if (m_tail.size() == DEPTH) set_ovf = 1;
            else begin
                m_head.push_back(spc + 16'd1);
                m_tail.push_back(spc + 16'(ln));
                m_left.push_back(cnt);
            end
        end else if (rv && m_tail.size() > 0 && rp == m_tail[m_tail.size()-1]) begin
            if (m_left[m_left.size()-1] > 1) begin
                exp_rv  = 1;
                exp_rpc = m_head[m_head.size()-1];
                m_left[m_left.size()-1] = m_left[m_left.size()-1] - 1;
            end else begin
                void'(m_head.pop_back());
                void'(m_tail.pop_back());
                void'(m_left.pop_back());
            end
        end
        #1;
        chk("redirect_valid", int'(redirect_valid), int'(exp_rv));
        if (exp_rv) chk("redirect_pc", int'(redirect_pc), int'(exp_rpc));
        chk("overflow_err", int'(overflow_err), int'(m_ovf));
        chk("cfg_err", int'(cfg_err), int'(m_cfg));
        if (set_ovf) m_ovf = 1;
        if (set_cfg) m_cfg = 1;
    endtask

    task automatic idle();
        step(0, 0, '0, '0, '0, '0, 0, '0);
    endtask

    task automatic retire(input logic [15:0] pc);
        step(0, 0, '0, '0, '0, '0, 1, pc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; start_valid = 0; retire_valid = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_head.delete(); m_tail.delete(); m_left.delete();
        m_ovf = 0; m_cfg = 0;
    endtask

    task automatic run_prog(input logic [15:0] entry, input logic [15:0] stop);
        logic [15:0] pc;
        int guard;
        pc = entry; guard = 0;
        while (pc != stop && guard < 2000) begin
            if (p_len.exists(int'(pc))) begin
                step(1, p_imm[int'(pc)], 16'(p_cnt[int'(pc)]), IMM_W'(p_cnt[int'(pc)]),
                     LEN_W'(p_len[int'(pc)]), pc, 0, '0);
                pc = pc + 16'd1;
            end else begin
                retire(pc);
                if (exp_rv) pc = exp_rpc;
                else pc = pc + 16'd1;
            end
            guard++;
        end
        if (guard >= 2000) chk("runner reached stop address", 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        do_reset();
        idle();
        retire(16'd0);

        // R2 R3 R4 R5: immediate count 3, body 11..13
        cur_tag = "R2 R3 R4 R5";
        p_len[10] = 3; p_cnt[10] = 3; p_imm[10] = 1;
        run_prog(16'd10, 16'd14);

        // R2: register count 2 with a different immediate on the bus
        cur_tag = "R2";
        step(1, 0, 16'd2, 6'd9, 8'd2, 16'd50, 0, '0);
        retire(16'd51); retire(16'd52); retire(16'd51); retire(16'd52);
        retire(16'd52);

        // R2: immediate selected, register field ignored, wide imm
        cur_tag = "R2";
        step(1, 1, 16'd0, 6'd63, 8'd1, 16'd60, 0, '0);
        for (int k = 0; k < 64; k++) retire(16'd61);

        // R6 R7: nested loops, outer 21..26 x2, inner 23..24 x3
        cur_tag = "R6 R7";
        p_len[20] = 6; p_cnt[20] = 2; p_imm[20] = 0;
        p_len[22] = 2; p_cnt[22] = 3; p_imm[22] = 1;
        run_prog(16'd20, 16'd27);

        // R6: branch away from the body and back
        cur_tag = "R6";
        step(1, 1, '0, 6'd2, 8'd4, 16'd100, 0, '0);
        retire(16'd101); retire(16'd300); retire(16'd301);
        retire(16'd102); retire(16'd103); retire(16'd104);
        retire(16'd101); retire(16'd104); retire(16'd104);

        // R8: shared end address; only top handled, outer left stale
        cur_tag = "R8";
        p_len[40] = 3; p_cnt[40] = 2; p_imm[40] = 1;
        p_len[41] = 2; p_cnt[41] = 2; p_imm[41] = 1;
        run_prog(16'd40, 16'd44);
        retire(16'd43); retire(16'd43); retire(16'd43);

        // R6: deeper frame match ignored while top differs
        cur_tag = "R6";
        step(1, 1, '0, 6'd3, 8'd2, 16'd70, 0, '0);
        step(1, 1, '0, 6'd2, 8'd1, 16'd80, 0, '0);
        retire(16'd72); retire(16'd81); retire(16'd81); retire(16'd72);

        // R11: start and retire in the same cycle
        cur_tag = "R11";
        step(1, 1, '0, 6'd2, 8'd3, 16'd90, 1, 16'd72);
        idle();

        // R10: zero count and zero length
        cur_tag = "R10";
        do_reset();
        step(1, 1, 16'd5, 6'd0, 8'd2, 16'd30, 0, '0);
        retire(16'd32); idle();
        step(1, 0, 16'd4, 6'd4, 8'd0, 16'd30, 0, '0);
        retire(16'd30); idle(); idle();

        // R9: overflow at DEPTH, sticky, top unchanged
        cur_tag = "R9";
        do_reset();
        for (int k = 0; k < DEPTH; k++)
            step(1, 1, '0, 6'd2, 8'd1, 16'(200 + 10 * k), 0, '0);
        step(1, 1, '0, 6'd2, 8'd1, 16'd500, 0, '0);
        retire(16'd501); idle();
        retire(16'(201 + 10 * (DEPTH - 1)));
        retire(16'(201 + 10 * (DEPTH - 1)));
        idle();
        // R10 priority over R9 when full
        cur_tag = "R10";
        for (int k = 0; k < DEPTH; k++)
            step(1, 1, '0, 6'd1, 8'd1, 16'(600 + 10 * k), 0, '0);
        step(1, 1, '0, 6'd0, 8'd1, 16'd700, 0, '0);
        idle();

        // R1: reset clears sticky flags and stack
        cur_tag = "R1";
        do_reset();
        idle();
        retire(16'(201));

        // Random mix against the reference model
        cur_tag = "R4 R5 R6 R8 R9 R10";
        for (int r = 0; r < 3000; r++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0 && r % 700 == 0) do_reset();
            else if (sel < 2)
                step(1, 1'($urandom_range(0, 1)), 16'($urandom_range(0, 3)),
                     IMM_W'($urandom_range(0, 3)), LEN_W'($urandom_range(0, 4)),
                     16'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                     16'($urandom_range(0, 20)));
            else if (sel < 9) retire(16'($urandom_range(0, 20)));
            else idle();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule